// File: doc/BRIEF.md
# Serial Flash Read Emulator with Early Word Fetch

The block acts as the slave end of a serial NOR flash read in SPI mode 0. The data itself lives in a 16-bit wide memory behind a burst controller. The host sends a read command byte and a 24-bit byte address. The block then streams bytes back on MISO for as long as chip select stays low, and moves through the address space in order.

Memory latency is hidden by issuing the word fetch as soon as address bit 2 has been shifted in, while bits 1 and 0 are still on the wire. Each fetch returns two 16-bit beats. The block joins them into one 32-bit word, and the last two address bits pick the starting byte. Once the first word has arrived, the following word is requested straight away, so crossing a word boundary causes no gap in the output.

All SPI pins are resampled in the system clock domain, so the system clock has to run at about six times the SCK rate or faster.

Top module: `spi_flash_rd_emu`

## Requirements
- R1: The memory request pulse (mem_req) appears after the 30th rising SCK edge of a read (the edge that samples address bit 2) and before the 31st. mem_addr then carries the 16-bit word address, which is address bits 23..2 followed by a 0.
- R2: A fetch takes two beats. The first beat holds the bytes at word offsets 0 (bits 7:0) and 1 (bits 15:8). The second beat holds offsets 2 (bits 7:0) and 3 (bits 15:8).
- R3: Address bits 1 and 0 select which of the four bytes of the fetched word is sent first.
- R4: Framing follows SPI mode 0. The first byte on MOSI, sent MSB first, must be 0x03, and the 24-bit address follows MSB first. MOSI is sampled on rising SCK, and MISO changes only on falling SCK. The first data bit appears on the falling edge after the 32nd rising edge, and each byte goes out MSB first. spi_miso_en stays low through the command and address and high through the data.
- R5: Bytes continue at consecutive addresses with no gap across 32-bit word boundaries, and the address wraps from 0xFFFFFF to 0x000000.
- R6: There is at most one outstanding request. Requests carry consecutive word addresses. A read of n bytes starting at byte offset k issues 2 + floor((k+n)/4) requests.
- R7: Raising chip select at any point drives spi_miso_en low within a few system clocks and returns the block to the command phase. Any fetch still in flight is discarded, and the next read returns correct data.
- R8: For a command byte other than 0x03, spi_miso_en stays low and no request is made until chip select rises.
- R9: The memory has 2.5 SCK periods from the request to the first data falling edge. The fetched word must be complete before that edge.
- R10: After reset, spi_miso_en, spi_miso and mem_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| spi_miso_en | output | 1 | MISO pad drive enable; low means the pad is high impedance |
| mem_req | output | 1 | One-cycle fetch request to the burst controller |
| mem_addr | output | 23 | 16-bit word address of the first beat of the fetch |
| mem_beat_valid | input | 1 | Marks a returned 16-bit beat |
| mem_beat_data | input | 16 | Returned beat data |

## Verification
The bench builds the block with its default 24-bit address and two-stage synchronizers. It runs SCK at one sixth of the system clock, which is about 33 MHz against a 200 MHz system clock. Its memory model answers after six system clocks. At that ratio the 2.5-period fetch window is tight enough that a fetch started one bit later would miss the first data edge. The chosen start addresses fall on every byte offset and include the top of the address space, so the byte selection, the prefetch hand-over and the address wrap are all exercised.

// File: rtl/spiemu_pkg.sv
// Shared types for the serial flash read emulator.
package spiemu_pkg;
    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_IGNORE
    } phase_e;
endpackage

// File: rtl/spiemu_sync.sv
// Multi-bit synchronizer: each input bit passes through its own STAGES-deep
// flop chain. Assumes the bits are independent, slowly changing level signals
// relative to clk. IDLE gives the reset value of each bit.
module spiemu_sync #(
    parameter int          W      = 2,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // Shift the raw pin through the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{IDLE[i]}};
            else        pipe <= {pipe[STAGES-2:0], d[i]};
        end
        assign q[i] = pipe[STAGES-1];
    end
endmodule

// File: rtl/spiemu_join.sv
// Joins two consecutive 16-bit beats into one 32-bit word; the first beat
// becomes the low half. Assumes beats of one burst are never interleaved
// with another burst.
module spiemu_join #(
    parameter int BEAT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid_i,
    input  logic [BEAT-1:0]   beat_data_i,
    output logic              word_valid_o,
    output logic [2*BEAT-1:0] word_data_o
);
    logic            second;
    logic [BEAT-1:0] low_half;

    // Hold the first beat, emit the word on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second       <= 1'b0;
            word_valid_o <= 1'b0;
            low_half     <= '0;
            word_data_o  <= '0;
        end else begin
            word_valid_o <= 1'b0;
            if (beat_valid_i) begin
                if (!second) begin
                    low_half <= beat_data_i;
                    second   <= 1'b1;
                end else begin
                    word_data_o  <= {beat_data_i, low_half};
                    word_valid_o <= 1'b1;
                    second       <= 1'b0;
                end
            end
        end
    end

    // A word follows a beat and never two words back to back.
    assert_word_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(beat_valid_i) && !$past(word_valid_o));
endmodule

// File: rtl/spiemu_fetch.sv
// Fetch engine: keeps the current 32-bit word and one prefetched word.
// A start issues the first request; the arrival of that word issues the
// next; each advance moves the next word to current and requests another.
// Assumes at most one request is outstanding (the SPI framing spaces them).
module spiemu_fetch #(
    parameter int WORD_BITS = 22,
    parameter int BEAT      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort_i,
    input  logic                 start_i,
    input  logic [WORD_BITS-1:0] start_word_i,
    input  logic                 advance_i,
    input  logic                 word_valid_i,
    input  logic [2*BEAT-1:0]    word_data_i,
    output logic [2*BEAT-1:0]    cur_word_o,
    output logic                 cur_ok_o,
    output logic                 nxt_ok_o,
    output logic                 mem_req_o,
    output logic [WORD_BITS:0]   mem_addr_o
);
    logic                 inflight, drop, tgt_nxt;
    logic [WORD_BITS-1:0] waddr, req_word;
    logic [2*BEAT-1:0]    nxt_word;
    logic                 take, take_cur, take_nxt, req_now;

    // Decide where a returning word goes and whether a request fires.
    always_comb begin
        take     = word_valid_i && inflight && !drop && !abort_i;
        take_cur = take && !tgt_nxt;
        take_nxt = take && tgt_nxt;
        req_now  = start_i || take_cur || advance_i;
        req_word = start_i ? start_word_i : waddr;
    end

    // Request issue, word buffers and in-flight bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight   <= 1'b0;
            drop       <= 1'b0;
            tgt_nxt    <= 1'b0;
            waddr      <= '0;
            cur_word_o <= '0;
            nxt_word   <= '0;
            cur_ok_o   <= 1'b0;
            nxt_ok_o   <= 1'b0;
            mem_req_o  <= 1'b0;
            mem_addr_o <= '0;
        end else begin
            mem_req_o <= req_now;
            if (req_now) begin
                mem_addr_o <= {req_word, 1'b0};
                waddr      <= req_word + 1'b1;
            end
            if (word_valid_i && (drop || abort_i)) begin
                inflight <= 1'b0;
                drop     <= 1'b0;
            end else if (abort_i && inflight) begin
                drop <= 1'b1;
            end
            if (abort_i) begin
                cur_ok_o <= 1'b0;
                nxt_ok_o <= 1'b0;
            end else begin
                if (start_i) begin
                    inflight <= 1'b1;
                    tgt_nxt  <= 1'b0;
                    cur_ok_o <= 1'b0;
                    nxt_ok_o <= 1'b0;
                end
                if (take_cur) begin
                    cur_word_o <= word_data_i;
                    cur_ok_o   <= 1'b1;
                    tgt_nxt    <= 1'b1;
                end
                if (take_nxt) begin
                    nxt_word <= word_data_i;
                    nxt_ok_o <= 1'b1;
                    inflight <= 1'b0;
                end
                if (advance_i) begin
                    cur_word_o <= nxt_word;
                    nxt_ok_o   <= 1'b0;
                    tgt_nxt    <= 1'b1;
                    inflight   <= 1'b1;
                end
            end
        end
    end

    // A new fetch never starts while another is outstanding.
    assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !inflight);
    // Moving to the next word requires it to be present already.
    assert_next_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |-> nxt_ok_o);
endmodule

// File: rtl/spi_flash_rd_emu.sv
// Serial flash read emulator, top level. Oversamples SCK, CS and MOSI on
// clk, decodes the read command and address, starts the word fetch once
// address bit 2 is in, and shifts bytes out MSB first on falling SCK.
// Assumes clk runs at six or more times the SCK frequency.
module spi_flash_rd_emu #(
    parameter int         ADDR_BITS   = 24,
    parameter logic [7:0] OPCODE      = 8'h03,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sck,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_en,
    output logic                   mem_req,
    output logic [ADDR_BITS-2:0]   mem_addr,
    input  logic                   mem_beat_valid,
    input  logic [15:0]            mem_beat_data
);
    import spiemu_pkg::*;

    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = ADDR_BITS - 2;
    localparam int HDR_BITS  = CMD_BITS + ADDR_BITS;
    localparam int CNT_W     = $clog2(HDR_BITS + 1);
    localparam int A2_AT     = HDR_BITS - 3;
    localparam int A0_AT     = HDR_BITS - 1;

    logic                 cs_idle, sck_s, mosi_s, sck_d;
    logic                 sck_rise, sck_fall, fall_data;
    phase_e               phase;
    logic [CNT_W-1:0]     cnt;
    logic [WORD_BITS-2:0] sr;
    logic [1:0]           byte_idx;
    logic [2:0]           bit_pos;
    logic [6:0]           tx_rest;
    logic                 start, advance, word_valid, cur_ok, nxt_ok;
    logic [31:0]          word_data, cur_word;
    logic [7:0]           cur_byte;
    logic [WORD_BITS-1:0] start_word;

    spiemu_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sck, spi_mosi}),
        .q({cs_idle, sck_s, mosi_s})
    );

    // Previous synchronized SCK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Edge strobes, fetch start, byte pick and word hand-over.
    always_comb begin
        sck_rise   = sck_s && !sck_d && !cs_idle;
        sck_fall   = !sck_s && sck_d && !cs_idle;
        fall_data  = sck_fall && (phase == PH_DATA);
        start      = sck_rise && (phase == PH_ADDR) && (cnt == CNT_W'(A2_AT));
        start_word = {sr, mosi_s};
        cur_byte   = cur_word[{byte_idx, 3'b000} +: 8];
        advance    = fall_data && (bit_pos == 3'd7) && (byte_idx == 2'd3);
    end

    spiemu_join #(.BEAT(16)) u_join (
        .clk(clk), .rst_n(rst_n),
        .beat_valid_i(mem_beat_valid), .beat_data_i(mem_beat_data),
        .word_valid_o(word_valid), .word_data_o(word_data)
    );

    spiemu_fetch #(.WORD_BITS(WORD_BITS), .BEAT(16)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .abort_i(cs_idle), .start_i(start), .start_word_i(start_word),
        .advance_i(advance), .word_valid_i(word_valid), .word_data_i(word_data),
        .cur_word_o(cur_word), .cur_ok_o(cur_ok), .nxt_ok_o(nxt_ok),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr)
    );

    // Command/address shifting and MSB-first byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_OPCODE;
            cnt         <= '0;
            sr          <= '0;
            byte_idx    <= '0;
            bit_pos     <= '0;
            tx_rest     <= '0;
            spi_miso    <= 1'b0;
            spi_miso_en <= 1'b0;
        end else if (cs_idle) begin
            phase       <= PH_OPCODE;
            cnt         <= '0;
            bit_pos     <= '0;
            spi_miso_en <= 1'b0;
        end else begin
            if (sck_rise && (phase == PH_OPCODE || phase == PH_ADDR)) begin
                sr  <= {sr[WORD_BITS-3:0], mosi_s};
                cnt <= cnt + 1'b1;
                if (phase == PH_OPCODE && cnt == CNT_W'(CMD_BITS - 1))
                    phase <= ({sr[6:0], mosi_s} == OPCODE) ? PH_ADDR : PH_IGNORE;
                if (phase == PH_ADDR && cnt == CNT_W'(A0_AT)) begin
                    phase    <= PH_DATA;
                    byte_idx <= {sr[0], mosi_s};
                end
            end
            if (fall_data) begin
                spi_miso_en <= 1'b1;
                bit_pos     <= bit_pos + 1'b1;
                if (bit_pos == 3'd0) begin
                    spi_miso <= cur_byte[7];
                    tx_rest  <= cur_byte[6:0];
                end else begin
                    spi_miso <= tx_rest[6];
                    tx_rest  <= {tx_rest[5:0], 1'b0};
                end
                if (bit_pos == 3'd7) byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // A fetch start is seen by the memory port one clock later.
    assert_fetch_on_a2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mem_req);
    // The first byte of a read must find its word already fetched.
    assert_word_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_data && bit_pos == 3'd0) |-> cur_ok);
    // Unknown command: no output drive and no memory traffic.
    assert_quiet_on_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> (!spi_miso_en && !mem_req));
    // Releasing chip select stops driving MISO.
    assert_release_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !spi_miso_en);
    // MISO only moves after a falling SCK edge.
    assert_miso_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> $past(sck_fall));
endmodule

// File: tb/sim_spi_flash_rd_emu.sv
module sim_spi_flash_rd_emu;
    localparam int HALF = 3;   // SCK half period in system clocks (~33 MHz)
    localparam int LAT  = 6;   // memory model latency in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic beat_v = 1'b0;
    logic [15:0] beat_d = '0;
    logic miso, miso_en, mem_req;
    logic [22:0] mem_addr;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int rise_cnt = 0;
    time last_fall_t = 0;
    int req_count = 0, first_req_rise = -1;
    logic [22:0] req_addrs [0:15];
    time first_word_t = 0;

    always #2.5 clk = ~clk;

    spi_flash_rd_emu u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_beat_valid(beat_v), .mem_beat_data(beat_d)
    );

    function automatic logic [7:0] fbyte(input logic [23:0] b);
        return b[7:0] ^ b[15:8] ^ b[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [15:0] mem16(input logic [22:0] a);
        return {fbyte({a, 1'b1}), fbyte({a, 1'b0})};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Memory model: two beats, LAT clocks after the request.
    initial begin : mem_model
        int tmr;
        int qidx;
        bit busy;
        logic [22:0] qa;
        busy = 0; tmr = 0; qidx = 0; qa = '0;
        forever begin
            @(negedge clk);
            beat_v = 1'b0;
            if (busy) begin
                tmr--;
                if (tmr == 1) begin
                    beat_v = 1'b1; beat_d = mem16(qa);
                end else if (tmr == 0) begin
                    beat_v = 1'b1; beat_d = mem16(qa + 23'd1); busy = 0;
                    if (qidx == 0) first_word_t = $time;
                end
            end
            if (rst_n && mem_req) begin
                busy = 1; tmr = LAT + 1; qa = mem_addr; qidx = req_count;
                if (req_count < 16) req_addrs[req_count] = mem_addr;
                if (req_count == 0) first_req_rise = rise_cnt;
                req_count++;
            end
        end
    end

    task automatic spi_bit(input logic mo, output logic mi, output logic en);
        mosi = mo;
        repeat (HALF) @(negedge clk);
        mi = miso; en = miso_en;
        sck = 1'b1; rise_cnt++;
        repeat (HALF) @(negedge clk);
        sck = 1'b0; last_fall_t = $time;
    endtask

    task automatic begin_txn();
        req_count = 0; first_req_rise = -1; rise_cnt = 0; first_word_t = 0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_txn();
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check(miso_en == 1'b0, "R7", "miso_en after CS release", miso_en, 0);
        repeat (8) @(negedge clk);
    endtask

    // Full read of n bytes plus extra partial bits; checks R1..R6, R9.
    task automatic do_read(input logic [23:0] addr, input int n, input int extra);
        logic mi, en;
        logic [7:0] got;
        logic [31:0] hdr;
        int en_hdr, en_data, reqs_exp;
        time t_first;
        hdr = {8'h03, addr};
        en_hdr = 0; en_data = 0;
        begin_txn();
        for (int i = 0; i < 32; i++) begin
            spi_bit(hdr[31-i], mi, en);
            if (en) en_hdr++;
        end
        t_first = last_fall_t;
        check(en_hdr == 0, "R4", "miso_en high during header", en_hdr, 0);
        check(first_req_rise == 30, "R1", "rise count at request", first_req_rise, 30);
        check(req_addrs[0] == {addr[23:2], 1'b0}, "R1", "request word address",
              req_addrs[0], {addr[23:2], 1'b0});
        check(first_word_t != 0 && first_word_t < t_first, "R9",
              "word arrival before first data edge", 32'(first_word_t), 32'(t_first));
        for (int b = 0; b < n; b++) begin
            got = '0;
            for (int k = 0; k < 8; k++) begin
                spi_bit(1'b0, mi, en);
                got = {got[6:0], mi};
                if (!en) en_data++;
            end
            // R2 R3 R5: byte mapping, first-byte pick and sequential run.
            check(got == fbyte(addr + 24'(b)), b == 0 ? "R3" : "R5",
                  $sformatf("byte %0d from 0x%06h", b, addr), got, fbyte(addr + 24'(b)));
        end
        for (int k = 0; k < extra; k++) spi_bit(1'b0, mi, en);
        check(en_data == 0, "R4", "miso_en low during data", en_data, 0);
        end_txn();
        reqs_exp = 2 + (int'(addr[1:0]) + n) / 4;
        check(req_count == reqs_exp, "R6", "request count", req_count, reqs_exp);
        for (int r = 1; r < req_count && r < 16; r++)
            check(req_addrs[r] == req_addrs[r-1] + 23'd2, "R6", "consecutive request",
                  req_addrs[r], req_addrs[r-1] + 23'd2);
    endtask

    task automatic test_reset();
        check(miso_en == 1'b0, "R10", "miso_en after reset", miso_en, 0);
        check(miso == 1'b0, "R10", "miso after reset", miso, 0);
        check(mem_req == 1'b0, "R10", "mem_req after reset", mem_req, 0);
    endtask

    task automatic test_bad_opcode();
        logic mi, en;
        logic [31:0] hdr;
        int en_cnt;
        hdr = {8'h0B, 24'h000100};
        en_cnt = 0;
        begin_txn();
        for (int i = 0; i < 48; i++) begin
            spi_bit(i < 32 ? hdr[31-i] : 1'b0, mi, en);
            if (en) en_cnt++;
        end
        repeat (4) @(negedge clk);
        check(en_cnt == 0, "R8", "miso_en on unknown command", en_cnt, 0);
        check(req_count == 0, "R8", "requests on unknown command", req_count, 0);
        end_txn();
    endtask

    task automatic test_abort_after_a2();
        logic mi, en;
        logic [31:0] hdr;
        hdr = {8'h03, 24'h000123};
        begin_txn();
        for (int i = 0; i < 30; i++) spi_bit(hdr[31-i], mi, en);
        repeat (2) @(negedge clk);
        check(req_count == 1, "R1", "request fired before A1", req_count, 1);
        end_txn();
        do_read(24'h0004F2, 6, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        do_read(24'h000000, 4, 0);
        do_read(24'h012346, 9, 0);
        do_read(24'h0ABCDF, 5, 0);
        do_read(24'hFFFFFD, 6, 0);
        test_bad_opcode();
        test_abort_after_a2();
        do_read(24'h345671, 3, 3);   // R7: release in the middle of a byte
        do_read(24'h345671, 4, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule